// File: doc/BRIEF.md
# Dual-Direction Storing Bus Transceiver

This block joins two 18-bit tri-state buses, called port A and port B. Each direction has its own storage cell. The A-to-B cell feeds port B and the B-to-A cell feeds port A. Each cell can work in one of four ways:

- transparent, following its input;
- held, keeping its value;
- edge-captured, loading on a rising strobe;
- edge-captured only while its active-low capture enable is asserted.

Each direction has four controls: an active-low drive enable, a level load enable, a capture strobe and an active-low capture enable. The two directions are fully independent and may drive at the same time.

All state sits in one system-clock domain. The capture strobes are treated as sampled signals, so a rising edge is seen when a strobe reads high at a system-clock edge after reading low at the edge before. Each port has a bus-hold keeper, and the input seen by the opposite cell passes through it.

The keeper has a per-bit float mask that marks bits no device drives. For a floating bit, the keeper returns the last value it resolved on that bit. For any other bit, it passes the pin value through and records it.

Top module: `dual_path_xcvr`

## Requirements
- R1: After reset both storage cells and both keepers hold 0, so an enabled output drives 0.
- R2: While a direction's load enable is high, its cell loads the seen input at every clock edge, so the output follows the input one clock later.
- R3: While the load enable is low and the strobe stays at a steady level, high or low, the cell keeps its value whatever the input does.
- R4: With the load enable low, a strobe sampled high at an edge after being sampled low at the previous edge, with the capture enable low (0 = enabled), loads the seen input at that edge.
- R5: A strobe rising edge seen while the capture enable is high (1 = blocked) leaves the cell unchanged.
- R6: While the load enable is high, strobe edges and the capture enable have no effect; the cell keeps tracking its input.
- R7: When a drive enable is low (0 = drive), the opposite port carries that cell's value. When it is high (1 = release), the port is high-impedance and another driver alone sets its value.
- R8: For a bit whose float mask bit is 1, the seen value is the last value the keeper resolved on that bit, which is 0 if nothing was resolved since reset. For a bit whose mask bit is 0, the seen value is the pin, and the keeper records it on every edge.
- R9: B-to-A behaves like A-to-B with its own controls. With both drive enables low and both load enables low, each port carries its own cell's value and neither cell disturbs the other.
- R10: The strobe history resets to high, so a strobe already high when reset is released is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_io | inout | WIDTH | Port A bus |
| b_io | inout | WIDTH | Port B bus |
| a_flt | input | WIDTH | Float mask for port A bits (1 = undriven) |
| b_flt | input | WIDTH | Float mask for port B bits (1 = undriven) |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_le | input | 1 | A-to-B load enable, active high |
| ab_strb | input | 1 | A-to-B capture strobe |
| ab_cke_n | input | 1 | A-to-B capture enable, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A load enable, active high |
| ba_strb | input | 1 | B-to-A capture strobe |
| ba_cke_n | input | 1 | B-to-A capture enable, active low |

## Verification
The hardest state to reach is both directions driving at once. The port each cell reads is then the other cell's own output, so any stray load would feed one cell into the other. The stimulus first fills each cell separately through capture, with the bench driving the source port and the other direction released. It then lets go of both buses and enables both outputs together with both load enables low, and checks that each port keeps its own value over several cycles. Keeper recall is reached in a similar way: the bench stops driving a port while the mask marks it floating, and a partial mask then shows old and new bits side by side.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  localparam int unsigned DPX_W = 18;
  localparam int unsigned DPX_NDIR = 2;

  // rising edge seen between two consecutive samples of a strobe
  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // load decision of one storage cell: level load wins, else gated edge
  function automatic logic cell_load(input logic le, input logic rise, input logic cke_n);
    return le | (rise & ~cke_n);
  endfunction

endpackage

// File: rtl/dpx_keeper.sv
module dpx_keeper
  import dpx_pkg::*;
#(
  parameter int unsigned W = DPX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] flt,
  output logic [W-1:0] seen
);

  logic [W-1:0] hold_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign seen[i] = flt[i] ? hold_q[i] : pin[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= seen;
  end

  // R8
  keep_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flt) |=> (((hold_q ^ $past(hold_q)) & $past(flt)) == '0));

endmodule

// File: rtl/dpx_path.sv
module dpx_path
  import dpx_pkg::*;
#(
  parameter int unsigned W = DPX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         strb,
  input  logic         cke_n,
  output logic [W-1:0] q
);

  logic strb_q;
  logic strb_rise;
  logic cell_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b1;
    else        strb_q <= strb;
  end

  assign strb_rise = rise_of(strb, strb_q);
  assign cell_ld   = cell_load(le, strb_rise, cke_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (cell_ld) q <= din;
  end

  // R2
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (q == $past(din)));

  // R3
  steady_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !strb_rise) |=> $stable(q));

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && strb_rise && !cke_n) |=> (q == $past(din)));

  // R5
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && cke_n) |=> $stable(q));

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import dpx_pkg::*;
#(
  parameter int unsigned WIDTH = DPX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  inout  wire  [WIDTH-1:0] a_io,
  inout  wire  [WIDTH-1:0] b_io,
  input  logic [WIDTH-1:0] a_flt,
  input  logic [WIDTH-1:0] b_flt,
  input  logic             ab_oe_n,
  input  logic             ab_le,
  input  logic             ab_strb,
  input  logic             ab_cke_n,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_strb,
  input  logic             ba_cke_n
);

  // index 0: port A / A-to-B direction, index 1: port B / B-to-A direction
  logic [WIDTH-1:0] pin_v  [DPX_NDIR];
  logic [WIDTH-1:0] flt_v  [DPX_NDIR];
  logic [WIDTH-1:0] seen_v [DPX_NDIR];
  logic [WIDTH-1:0] q_v    [DPX_NDIR];
  logic             le_v   [DPX_NDIR];
  logic             strb_v [DPX_NDIR];
  logic             cke_v  [DPX_NDIR];

  assign pin_v[0]  = a_io;
  assign pin_v[1]  = b_io;
  assign flt_v[0]  = a_flt;
  assign flt_v[1]  = b_flt;
  assign le_v[0]   = ab_le;
  assign le_v[1]   = ba_le;
  assign strb_v[0] = ab_strb;
  assign strb_v[1] = ba_strb;
  assign cke_v[0]  = ab_cke_n;
  assign cke_v[1]  = ba_cke_n;

  generate
    for (genvar d = 0; d < DPX_NDIR; d++) begin : g_dir
      dpx_keeper #(.W(WIDTH)) u_keep (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_v[d]),
        .flt   (flt_v[d]),
        .seen  (seen_v[d])
      );

      dpx_path #(.W(WIDTH)) u_path (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (seen_v[d]),
        .le    (le_v[d]),
        .strb  (strb_v[d]),
        .cke_n (cke_v[d]),
        .q     (q_v[d])
      );
    end
  endgenerate

  // each cell drives the port opposite its source
  assign b_io = ab_oe_n ? {WIDTH{1'bz}} : q_v[0];
  assign a_io = ba_oe_n ? {WIDTH{1'bz}} : q_v[1];

endmodule

// File: tb/dual_path_xcvr_bench.sv
`timescale 1ns/1ps
module dual_path_xcvr_bench;

  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] tb_a_val = '0, tb_b_val = '0;
  logic         tb_a_en = 1'b0, tb_b_en = 1'b0;
  logic [W-1:0] a_flt = '0, b_flt = '0;
  logic ab_oe_n = 1'b0, ab_le = 1'b0, ab_strb = 1'b0, ab_cke_n = 1'b1;
  logic ba_oe_n = 1'b0, ba_le = 1'b0, ba_strb = 1'b0, ba_cke_n = 1'b1;

  wire [W-1:0] a_bus;
  wire [W-1:0] b_bus;
  assign a_bus = tb_a_en ? tb_a_val : {W{1'bz}};
  assign b_bus = tb_b_en ? tb_b_val : {W{1'bz}};

  dual_path_xcvr u_dual_path_xcvr (
    .clk(clk), .rst_n(rst_n), .a_io(a_bus), .b_io(b_bus),
    .a_flt(a_flt), .b_flt(b_flt),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_strb(ab_strb), .ab_cke_n(ab_cke_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_strb(ba_strb), .ba_cke_n(ba_cke_n)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference: index 0 = A-to-B cell / port A keeper
  logic [W-1:0] m_q [2];
  logic [W-1:0] m_keep [2];
  bit           m_prev [2];

  always @(posedge clk) begin
    logic [W-1:0] pa, pb, sa, sb;
    bit ra, rb;
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_q[k] = '0; m_keep[k] = '0; m_prev[k] = 1'b1;
      end
    end else begin
      pa = tb_a_en ? tb_a_val : (!ba_oe_n ? m_q[1] : '0);
      pb = tb_b_en ? tb_b_val : (!ab_oe_n ? m_q[0] : '0);
      for (int i = 0; i < W; i++) begin
        sa[i] = a_flt[i] ? m_keep[0][i] : pa[i];
        sb[i] = b_flt[i] ? m_keep[1][i] : pb[i];
      end
      m_keep[0] = sa; m_keep[1] = sb;
      ra = ab_strb && !m_prev[0];
      rb = ba_strb && !m_prev[1];
      m_prev[0] = ab_strb; m_prev[1] = ba_strb;
      if (ab_le || (ra && !ab_cke_n)) m_q[0] = sa;
      if (ba_le || (rb && !ba_cke_n)) m_q[1] = sb;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    if (rst_n) begin
      if (!ab_oe_n)     chk(cur_req, "model port B", b_bus, m_q[0]);
      else if (tb_b_en) chk("R7", "released port B", b_bus, tb_b_val);
      if (!ba_oe_n)     chk(cur_req, "model port A", a_bus, m_q[1]);
      else if (tb_a_en) chk("R7", "released port A", a_bus, tb_a_val);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1", "reset B", b_bus, '0);
    chk("R1", "reset A", a_bus, '0);

    // R2 transparent A-to-B
    cur_req = "R2";
    ba_oe_n = 1'b1; tb_a_en = 1'b1; ab_le = 1'b1; tb_a_val = 18'h2A5C3;
    tick(); chk("R2", "follow 1", b_bus, 18'h2A5C3);
    tb_a_val = 18'h15A3C;
    tick(); chk("R2", "follow 2", b_bus, 18'h15A3C);

    // R3 hold with strobe steady low, then steady high
    cur_req = "R3";
    ab_le = 1'b0; tick();
    tb_a_val = 18'h3FFFF; tick(); chk("R3", "hold low strobe", b_bus, 18'h15A3C);
    cur_req = "R5";
    ab_cke_n = 1'b1; ab_strb = 1'b1; tick(); chk("R5", "blocked edge", b_bus, 18'h15A3C);
    cur_req = "R3";
    ab_cke_n = 1'b0; tick(); tick(); chk("R3", "hold high strobe", b_bus, 18'h15A3C);

    // R4 gated capture
    cur_req = "R4";
    ab_strb = 1'b0; tick();
    tb_a_val = 18'h0F0F0; ab_strb = 1'b1; tick(); chk("R4", "capture", b_bus, 18'h0F0F0);
    tb_a_val = 18'h12345; tick(); chk("R3", "after capture", b_bus, 18'h0F0F0);

    // R5 capture enable high blocks edge
    cur_req = "R5";
    ab_strb = 1'b0; tick();
    ab_cke_n = 1'b1; tb_a_val = 18'h3C3C3; ab_strb = 1'b1; tick();
    chk("R5", "edge blocked", b_bus, 18'h0F0F0);

    // R6 load enable wins
    cur_req = "R6";
    ab_le = 1'b1; ab_strb = 1'b0; tb_a_val = 18'h00777; tick();
    chk("R6", "le over strobe low", b_bus, 18'h00777);
    ab_strb = 1'b1; ab_cke_n = 1'b0; tb_a_val = 18'h2BEEF; tick();
    chk("R6", "le over edge", b_bus, 18'h2BEEF);

    // R7 release and drive
    cur_req = "R7";
    ab_oe_n = 1'b1; tb_b_en = 1'b1; tb_b_val = 18'h1D1D1; tick();
    chk("R7", "port B released", b_bus, 18'h1D1D1);
    tb_b_en = 1'b0; ab_oe_n = 1'b0; tick();
    chk("R7", "port B driven", b_bus, 18'h2BEEF);

    // R9 B-to-A direction
    cur_req = "R9";
    ab_le = 1'b0; ab_oe_n = 1'b1; tb_a_en = 1'b0; tb_b_en = 1'b1;
    ba_oe_n = 1'b0; ba_le = 1'b1; tb_b_val = 18'h30A0B; tick();
    chk("R9", "B-to-A follow", a_bus, 18'h30A0B);
    ba_le = 1'b0; ba_cke_n = 1'b0; ba_strb = 1'b0; tick();
    tb_b_val = 18'h01F2E; ba_strb = 1'b1; tick();
    chk("R9", "B-to-A capture", a_bus, 18'h01F2E);
    tb_b_val = 18'h22222; tick();
    chk("R9", "B-to-A hold", a_bus, 18'h01F2E);
    tb_b_en = 1'b0; ab_oe_n = 1'b0; tick();
    chk("R9", "both on B", b_bus, 18'h2BEEF);
    chk("R9", "both on A", a_bus, 18'h01F2E);
    tick(); tick();
    chk("R9", "both stay B", b_bus, 18'h2BEEF);
    chk("R9", "both stay A", a_bus, 18'h01F2E);

    // R8 keeper
    cur_req = "R8";
    ba_oe_n = 1'b1; tb_a_en = 1'b1; tb_a_val = 18'h155AA; ab_le = 1'b1; tick();
    chk("R8", "keeper primed", b_bus, 18'h155AA);
    tb_a_en = 1'b0; a_flt = '1; tick(); tick();
    chk("R8", "keeper recall", b_bus, 18'h155AA);
    tb_a_en = 1'b1; tb_a_val = 18'h3FFFF; a_flt = 18'h001FF; tick();
    chk("R8", "partial float", b_bus, 18'h3FFAA);
    a_flt = '0; tick();
    chk("R8", "float cleared", b_bus, 18'h3FFFF);

    // R10 strobe high through reset release
    cur_req = "R10";
    rst_n = 1'b0; ab_strb = 1'b1; ab_cke_n = 1'b0; ab_le = 1'b0; tb_a_val = 18'h2AAAA;
    tick(); tick();
    rst_n = 1'b1; tick(); chk("R10", "no edge at release", b_bus, '0);
    tick(); chk("R10", "still held", b_bus, '0);
    ab_strb = 1'b0; tick();
    ab_strb = 1'b1; tick(); chk("R4", "first real edge", b_bus, 18'h2AAAA);

    // R8 keeper before any resolved value
    cur_req = "R8";
    rst_n = 1'b0; tick();
    a_flt = '1; tb_a_en = 1'b0; ab_le = 1'b1; rst_n = 1'b1; tick();
    chk("R8", "keeper reset value", b_bus, '0);
    tick(); chk("R8", "keeper reset stays", b_bus, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule